// File: doc/BRIEF.md
# Clock-Stop SPI Master with Programmable Serial Clock

This block is a serial peripheral interface master that moves one word per request. A word of 4 to 32 bits leaves on the data-out line most significant bit first, and a word of the same length is captured from the data-in line at the same time. The serial clock runs only during a transfer and rests low between transfers. Its rate comes from an 8-bit divisor of the system clock: one serial period lasts divisor plus one system cycles. When the divisor is even, the high phase is one cycle longer than the low phase.

A host presents the divisor, the word length and the transmit word, then pulses `start_i`. The block latches all three, drives the active-low select, places the first bit on data-out and enables the data-out driver. It then runs one low lead phase followed by one high phase per bit. Data-in is sampled on each rising serial edge. Later bits are launched on falling edges. After the last high phase, the driver enable drops with the final falling edge. One low tail phase follows, and then the select returns high. In that same cycle `done_o` pulses and the received word appears on `rx_word_o`. A start request made while a transfer runs has no effect.

The controller has five states. `IDLE` waits for a start request (transition *launch*). `LEAD` holds the select low and the clock low for one low phase (*first-rise*). `HIGH` is a clock-high phase. It ends either in a *fall* to `LOW` while bits remain, or in a *last-fall* to `TAIL`. `LOW` is a clock-low phase between bits (*rise* back to `HIGH`). `TAIL` holds the select low with the driver off for one low phase and then goes back to `IDLE` (*finish*, which pulses `done_o`).

Top module: `spi_clkstop_master`

## Requirements
- R1: The serial clock period is D+1 system cycles, where D is the latched divisor; a divisor input of 0 is treated as D=1, giving a clock at half the system rate.
- R2: For even D the serial clock stays high for D/2+1 cycles and low for D/2 cycles in every phase, including the lead and tail phases.
- R3: For odd D both the high and the low phase of the serial clock last (D+1)/2 cycles.
- R4: On a start request, `ss_n_o` falls and `busy_o` rises in the next cycle; the first rising serial edge follows one full low phase later; `busy_o` rises only after a start request.
- R5: Bits leave on `mosi_o` most significant bit first; `mosi_o` changes only together with a falling serial edge (or when the select falls); `miso_i` is sampled at each rising serial edge.
- R6: `mosi_oe_o` (1 = drive data-out, 0 = high impedance) is 1 from the select falling until the falling edge after the last rising edge, where it drops to 0 in the same cycle as the clock.
- R7: Whenever `ss_n_o` is high, `sclk_o` and `mosi_oe_o` are both 0.
- R8: `done_o` is a one-cycle pulse in the cycle `ss_n_o` returns high; `rx_word_o` then holds the received bits right-aligned (first bit received at bit L-1), with all bits above L equal to 0.
- R9: A start request while `busy_o` is 1 is ignored; the divisor, length and transmit word are latched when a transfer starts, so changes during a transfer have no effect.
- R10: The word length L is `len_i` clamped to the range 4..32; the number of rising serial edges in a transfer is L.
- R11: After reset `ss_n_o` is 1; `sclk_o`, `mosi_oe_o`, `busy_o` and `done_o` are 0; and `rx_word_o` is 0.
- R12: From the clock edge that accepts a start to the edge that raises `done_o`, exactly L*(D+1) + low-phase cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request, sampled when idle |
| div_i | input | 8 | Serial clock divisor D (0 treated as 1) |
| len_i | input | 6 | Word length, clamped to 4..32 |
| tx_word_i | input | 32 | Transmit word, low L bits used |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock, low when idle |
| ss_n_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Driver enable for serial data out |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_word_o | output | 32 | Last received word |

## Verification
On every cycle the assertions check the idle-clock rule, the coupling of the driver enable with the select and the final falling edge, that data-out is stable while the clock is high, the one-cycle done pulse, and that activity begins only after a start request. The exact phase widths for even and odd divisors, the divisor-zero substitution, length clamping, bit order in both directions, total transfer length, and the ignoring of a start request made mid-transfer are shown only by the bench. The bench does this with a slave model and a phase-width monitor across directed and random transfers.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } xfer_state_t;

endpackage

// File: rtl/spi_clk_phase.sv
module spi_clk_phase #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] hi_len_o,
    output logic [DIV_W-1:0] lo_len_o
);
    // div_i is already sanitized (never 0)
    logic [DIV_W-1:0] half_dn;
    logic [DIV_W-1:0] half_up;

    always_comb begin
        half_dn = div_i >> 1;
        half_up = half_dn + DIV_W'(div_i[0]);
        if (div_i[0]) begin
            hi_len_o = half_up;
            lo_len_o = half_up;
        end else begin
            hi_len_o = half_dn + DIV_W'(1);
            lo_len_o = half_dn;
        end
    end

endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q > CNT_W'(1)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int WORD_MAX = 32,
    parameter int LEN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [WORD_MAX-1:0] tx_i,
    input  logic                shift_tx_i,
    input  logic                sample_i,
    input  logic                miso_i,
    output logic                tx_bit_o,
    output logic [WORD_MAX-1:0] rx_o
);
    logic [WORD_MAX-1:0] tx_q;
    logic [WORD_MAX-1:0] rx_q;
    logic [LEN_W-1:0]    align;

    always_comb begin
        align = LEN_W'(WORD_MAX) - len_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load_i) begin
            tx_q <= tx_i << align;
            rx_q <= '0;
        end else begin
            if (shift_tx_i) begin
                tx_q <= {tx_q[WORD_MAX-2:0], 1'b0};
            end
            if (sample_i) begin
                rx_q <= {rx_q[WORD_MAX-2:0], miso_i};
            end
        end
    end

    assign tx_bit_o = tx_q[WORD_MAX-1];
    assign rx_o     = rx_q;

endmodule

// File: rtl/spi_clkstop_master.sv
module spi_clkstop_master
    import spi_cs_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int WORD_MAX = 32,
    parameter int WORD_MIN = 4,
    parameter int LEN_W    = $clog2(WORD_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [WORD_MAX-1:0] tx_word_i,
    input  logic                miso_i,
    output logic                sclk_o,
    output logic                ss_n_o,
    output logic                mosi_o,
    output logic                mosi_oe_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [WORD_MAX-1:0] rx_word_o
);
    localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(WORD_MIN);
    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(WORD_MAX);

    xfer_state_t state_q, state_nx;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_in_safe;
    logic [DIV_W-1:0] div_eff;
    logic [LEN_W-1:0] len_clamped;
    logic [LEN_W-1:0] bits_left_q;
    logic [DIV_W-1:0] hi_len;
    logic [DIV_W-1:0] lo_len;
    logic             phase_last;
    logic             timer_load;
    logic [DIV_W-1:0] timer_val;
    logic             accept;
    logic             fall_ev;
    logic             rise_ev;
    logic             tx_bit;
    logic [WORD_MAX-1:0] rx_bits;

    // Input conditioning: divisor 0 becomes 1, length clamped
    always_comb begin
        div_in_safe = (div_i == '0) ? DIV_W'(1) : div_i;
        if (len_i < LEN_LO)      len_clamped = LEN_LO;
        else if (len_i > LEN_HI) len_clamped = LEN_HI;
        else                     len_clamped = len_i;
        div_eff = (state_q == ST_IDLE) ? div_in_safe : div_q;
    end

    assign accept = (state_q == ST_IDLE) && start_i;

    spi_clk_phase #(.DIV_W(DIV_W)) u_phase (
        .div_i    (div_eff),
        .hi_len_o (hi_len),
        .lo_len_o (lo_len)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)    state_nx = ST_LEAD;
            ST_LEAD: if (phase_last) state_nx = ST_HIGH;
            ST_HIGH: if (phase_last) state_nx = (bits_left_q == LEN_W'(1)) ? ST_TAIL : ST_LOW;
            ST_LOW:  if (phase_last) state_nx = ST_HIGH;
            ST_TAIL: if (phase_last) state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    assign fall_ev    = (state_q == ST_HIGH) && (state_nx == ST_LOW);
    assign rise_ev    = (state_q != ST_HIGH) && (state_nx == ST_HIGH);
    assign timer_load = (state_nx != state_q);
    assign timer_val  = (state_nx == ST_HIGH) ? hi_len : lo_len;

    spi_phase_timer #(.CNT_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .last_o     (phase_last)
    );

    spi_word_shifter #(.WORD_MAX(WORD_MAX), .LEN_W(LEN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .len_i      (len_clamped),
        .tx_i       (tx_word_i),
        .shift_tx_i (fall_ev),
        .sample_i   (rise_ev),
        .miso_i     (miso_i),
        .tx_bit_o   (tx_bit),
        .rx_o       (rx_bits)
    );

    // State register with transfer configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            div_q       <= DIV_W'(1);
            bits_left_q <= '0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                div_q       <= div_in_safe;
                bits_left_q <= len_clamped;
            end else if (fall_ev) begin
                bits_left_q <= bits_left_q - LEN_W'(1);
            end
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o    <= 1'b0;
            ss_n_o    <= 1'b1;
            mosi_oe_o <= 1'b0;
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            rx_word_o <= '0;
        end else begin
            sclk_o    <= (state_nx == ST_HIGH);
            ss_n_o    <= (state_nx == ST_IDLE);
            mosi_oe_o <= (state_nx == ST_LEAD) || (state_nx == ST_HIGH) || (state_nx == ST_LOW);
            busy_o    <= (state_nx != ST_IDLE);
            done_o    <= (state_q == ST_TAIL) && (state_nx == ST_IDLE);
            if ((state_q == ST_TAIL) && (state_nx == ST_IDLE)) begin
                rx_word_o <= rx_bits;
            end
        end
    end

    assign mosi_o = mosi_oe_o & tx_bit;

endmodule

// File: rtl/spi_clkstop_master_chk.sv
module spi_clkstop_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic sclk_o,
    input logic ss_n_o,
    input logic mosi_o,
    input logic mosi_oe_o,
    input logic busy_o,
    input logic done_o
);
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> (!sclk_o && !mosi_oe_o));

    a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    a_r6_oe_drop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mosi_oe_o) |-> $fell(sclk_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_with_ss_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n_o) |-> done_o);

    a_r4_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r4_ss_falls_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n_o) |-> !sclk_o);

endmodule

bind spi_clkstop_master spi_clkstop_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sclk_o    (sclk_o),
    .ss_n_o    (ss_n_o),
    .mosi_o    (mosi_o),
    .mosi_oe_o (mosi_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/sim_spi_clkstop_master.sv
`timescale 1ns/1ps
module sim_spi_clkstop_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  div_i = 8'd1;
    logic [5:0]  len_i = 6'd8;
    logic [31:0] tx_word_i = '0;
    logic        miso_i = 1'b0;
    logic        sclk_o, ss_n_o, mosi_o, mosi_oe_o, busy_o, done_o;
    logic [31:0] rx_word_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_clkstop_master u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
        .len_i(len_i), .tx_word_i(tx_word_i), .miso_i(miso_i),
        .sclk_o(sclk_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o),
        .mosi_oe_o(mosi_oe_o), .busy_o(busy_o), .done_o(done_o),
        .rx_word_o(rx_word_o)
    );

    function automatic int f_div(input int d);
        return (d == 0) ? 1 : d;
    endfunction
    function automatic int f_hi(input int d);
        int e = f_div(d);
        return (e % 2 == 0) ? e / 2 + 1 : (e + 1) / 2;
    endfunction
    function automatic int f_lo(input int d);
        int e = f_div(d);
        return (e % 2 == 0) ? e / 2 : (e + 1) / 2;
    endfunction
    function automatic int f_len(input int l);
        return (l < 4) ? 4 : ((l > 32) ? 32 : l);
    endfunction
    function automatic logic [31:0] f_mask(input int l);
        logic [63:0] m = (64'd1 << l) - 64'd1;
        return m[31:0];
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Monitor and slave model, sampled at negedge
    int          exp_hi, exp_lo, exp_len;
    int          run_len, rises, mon_err;
    logic        prev_sclk = 1'b0, prev_ss = 1'b1;
    logic [31:0] cap_mosi, slv_word;
    int          slv_idx;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ss && !ss_n_o) begin
                run_len = 1; rises = 0; cap_mosi = '0;
                miso_i  = slv_word[exp_len-1];
                slv_idx = exp_len - 2;
                if (!mosi_oe_o) mon_err++;
            end else if (!ss_n_o) begin
                if (sclk_o == prev_sclk) begin
                    run_len++;
                end else begin
                    if (prev_sclk && run_len != exp_hi) mon_err++;
                    if (!prev_sclk && run_len != exp_lo) mon_err++;
                    run_len = 1;
                    if (sclk_o) begin
                        cap_mosi = {cap_mosi[30:0], mosi_o};
                        rises++;
                        if (!mosi_oe_o) mon_err++;
                    end else begin
                        if (rises == exp_len && mosi_oe_o) mon_err++;
                        if (rises < exp_len && !mosi_oe_o) mon_err++;
                        if (slv_idx >= 0) begin
                            miso_i = slv_word[slv_idx];
                            slv_idx--;
                        end
                    end
                end
            end else if (!prev_ss && ss_n_o) begin
                if (run_len != exp_lo || prev_sclk) mon_err++;
            end
            prev_sclk = sclk_o;
            prev_ss   = ss_n_o;
        end
    end

    task automatic run_xfer(input int d, input int l, input logic [31:0] tx,
                            input logic [31:0] sw, input bit inject);
        int n;
        int L = f_len(l);
        int T;
        T = L * (f_hi(d) + f_lo(d)) + f_lo(d);
        exp_hi = f_hi(d); exp_lo = f_lo(d); exp_len = L;
        slv_word = sw; mon_err = 0;
        @(negedge clk);
        div_i = 8'(d); len_i = 6'(l); tx_word_i = tx; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; n = 1;
        check(busy_o == 1'b1 && ss_n_o == 1'b0, "R4 select low and busy after start",
              {busy_o, ss_n_o}, 2'b10);
        while (!done_o && n < 100000) begin
            if (inject) begin
                start_i = (n == 3);
                div_i = 8'd7; len_i = 6'd13; tx_word_i = ~tx;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check(n == T + 1, "R12 transfer cycles", n, T + 1);
        check(rx_word_o == (sw & f_mask(L)), "R8 received word right-aligned",
              rx_word_o, sw & f_mask(L));
        check((cap_mosi & f_mask(L)) == (tx & f_mask(L)), "R5 mosi bits msb first",
              cap_mosi & f_mask(L), tx & f_mask(L));
        check(rises == L, "R10 rising edge count", rises, L);
        check(mon_err == 0, (f_div(d) % 2 == 0) ? "R2 even phase widths/R6 oe" :
              "R3 odd phase widths/R6 oe", mon_err, 0);
        check(ss_n_o == 1'b1, "R8 select high with done", ss_n_o, 1);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done single pulse", done_o, 0);
        @(negedge clk);
        check(busy_o == 1'b0 && ss_n_o == 1'b1 && sclk_o == 1'b0,
              inject ? "R9 no restart from ignored start" : "R7 idle after transfer",
              {busy_o, ss_n_o, sclk_o}, 3'b010);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        check(ss_n_o == 1 && sclk_o == 0 && mosi_oe_o == 0 && busy_o == 0 &&
              done_o == 0 && rx_word_o == 0, "R11 reset state",
              {ss_n_o, sclk_o, mosi_oe_o, busy_o, done_o}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk_o == 0 && ss_n_o == 1, "R7 clock stopped while idle", sclk_o, 0);

        run_xfer(1, 8, 32'hA5, 32'h3C, 0);                    // R1 half rate
        run_xfer(0, 8, 32'h5A, 32'hC3, 0);                    // R1 divisor 0 as 1
        run_xfer(2, 32, 32'hDEADBEEF, 32'h13579BDF, 0);       // R2 even
        run_xfer(3, 4, 32'h9, 32'h6, 0);                      // R3 odd
        run_xfer(255, 4, 32'hF, 32'hA, 0);                    // R3 max divisor
        run_xfer(254, 5, 32'h15, 32'h0A, 0);                  // R2 large even
        run_xfer(4, 2, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0);      // R10 clamp low
        run_xfer(5, 40, 32'h8000_0001, 32'h7FFF_FFFE, 0);     // R10 clamp high
        run_xfer(6, 12, 32'hABC, 32'h123, 1);                 // R9 start while busy

        for (int i = 0; i < 14; i++) begin
            int d = $urandom_range(0, 20);
            int l = $urandom_range(0, 40);
            run_xfer(d, l, $urandom, $urandom, (i % 4) == 1);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule